// File: doc/BRIEF.md
# Power-Up, Sleep and Interrupt-Pin Controller

This block governs the power state of a serial peripheral and decides what its single interrupt pin means. After any reset the pin is a "ready" indicator: it is held low while an internal power-up timer runs, then goes high to tell the host that the device can be programmed. Once software sets the interrupt-select mode bit, the same pin becomes an active-low interrupt line that follows the pending flag from the interrupt status logic.

The block also puts the device to sleep in two ways. In the first, an inactivity timer runs while automatic sleep is enabled and the datapath reports no activity. In the second, the forced-sleep bit sends the device to sleep at once. Every move between awake and asleep raises a one-cycle sleep status interrupt. The current sleep state is brought out for register readback, and a clock-enable output gates the datapath clocks while the device sleeps.

The mode bits come from the register file, which clears them on hardware or software reset. A software reset strobe restarts this block's own state. The asynchronous reset is released into the block through a two-flop synchronizer.

Top module: `pwr_irq_ctrl`

## Requirements
- R1: While rst_n is low, irq_n_o is 0, sleep_state_o is 0, clk_en_o is 1 and sleep_int_o is 0.
- R2: In power-up mode (irq_mode_i = 0), irq_n_o stays 0 through the first POR_CYCLES+1 rising edges after rst_n is released. It is 1 from edge POR_CYCLES+2 onward, whatever int_pending_i is. The two extra edges come from the reset synchronizer. Before the device is ready, irq_n_o is 0 in either mode.
- R3: Once the device is ready and irq_mode_i = 1, irq_n_o equals the inverse of int_pending_i without a clock delay. It is 0 while an interrupt is pending.
- R4: If auto_sleep_i = 1 and activity_i = 0 starting from an edge at which the device is awake and the idle count is zero, the device stays awake through the next IDLE_CYCLES edges and is asleep after edge IDLE_CYCLES+1.
- R5: An activity_i pulse while awake restarts the inactivity count, so the full R4 window starts again from the edge after the pulse.
- R6: While auto_sleep_i = 0, the inactivity timer does not run and the device never enters sleep on its own.
- R7: forced sleep: force_sleep_i = 1 puts the device asleep at the next edge, even while activity_i = 1.
- R8: From automatic sleep with force_sleep_i = 0, the device is awake at the next edge after activity_i = 1 or after auto_sleep_i = 0.
- R9: From forced sleep, activity_i has no effect. The device wakes at the next edge after force_sleep_i returns to 0.
- R10: sleep_int_o is a one-cycle pulse, high in exactly the first cycle after every awake-to-asleep or asleep-to-awake change. It is never high in any other cycle.
- R11: sleep_state_o is 1 exactly when the device is asleep, and clk_en_o is its inverse. Both are valid in every state.
- R12: A soft_rst_i pulse wakes the device at the next edge without a sleep status pulse. It also restarts the power-up count, so irq_n_o (with irq_mode_i = 0) is 0 after that edge and 1 again POR_CYCLES edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst_i | input | 1 | Synchronous software reset strobe |
| irq_mode_i | input | 1 | Interrupt-select mode bit: 0 = ready signalling, 1 = interrupt line |
| auto_sleep_i | input | 1 | Enables sleep after inactivity |
| force_sleep_i | input | 1 | Requests immediate sleep |
| activity_i | input | 1 | Activity pulse from the serial datapath |
| int_pending_i | input | 1 | Any enabled interrupt status bit is pending |
| irq_n_o | output | 1 | Interrupt pin level |
| sleep_state_o | output | 1 | Current sleep state for readback |
| sleep_int_o | output | 1 | One-cycle pulse on every sleep or wake transition |
| clk_en_o | output | 1 | Clock enable for the datapath, low while asleep |

## Verification
The hardest case to reach from the ports is the exact edge at which automatic sleep begins. The idle counter cannot be seen from outside, so it has to be brought to a known zero first. The bench does this by waking the device with an activity pulse from automatic sleep. It then holds activity low for a counted number of edges and checks the state one edge before the deadline and again at the deadline. It repeats the run with an activity pulse inserted close to expiry, which shows that the count restarts. Forced sleep is then placed over a busy activity input to show that activity cannot end it.

// File: rtl/pwr_irq_pkg.sv
package pwr_irq_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE     = 2'd0,
    ST_AUTO_SLP  = 2'd1,
    ST_FORCE_SLP = 2'd2
  } slp_state_e;

endpackage

// File: rtl/pic_por_timer.sv
module pic_por_timer #(
  parameter int unsigned POR_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(POR_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = soft_rst_i || (cnt_q != LIMIT);
    cnt_d  = soft_rst_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready_o = (cnt_q == LIMIT);

  // R12
  soft_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> !ready_o);

endmodule

// File: rtl/pic_idle_timer.sv
module pic_idle_timer #(
  parameter int unsigned IDLE_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst_i,
  input  logic auto_sleep_i,
  input  logic awake_i,
  input  logic activity_i,
  output logic timeout_o
);
  localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          run;

  always_comb begin
    run = auto_sleep_i && awake_i && !activity_i && !soft_rst_i;
    if (!run)                cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign timeout_o = (cnt_q == LIMIT);

  // R4
  idle_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R5
  activity_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    activity_i |=> !timeout_o);

  // R6
  auto_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_sleep_i |=> !timeout_o);

endmodule

// File: rtl/pic_sleep_fsm.sv
module pic_sleep_fsm
  import pwr_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst_i,
  input  logic auto_sleep_i,
  input  logic force_sleep_i,
  input  logic activity_i,
  input  logic timeout_i,
  output logic asleep_o,
  output logic sleep_int_o
);
  slp_state_e state_q, state_d;
  logic       pulse_q, pulse_d;

  always_comb begin
    state_d = state_q;
    if (soft_rst_i) begin
      state_d = ST_AWAKE;
    end else begin
      case (state_q)
        ST_AWAKE: begin
          if (force_sleep_i)  state_d = ST_FORCE_SLP;
          else if (timeout_i) state_d = ST_AUTO_SLP;
        end
        ST_AUTO_SLP: begin
          if (force_sleep_i)                    state_d = ST_FORCE_SLP;
          else if (activity_i || !auto_sleep_i) state_d = ST_AWAKE;
        end
        ST_FORCE_SLP: begin
          if (!force_sleep_i) state_d = ST_AWAKE;
        end
        default: state_d = ST_AWAKE;
      endcase
    end
    pulse_d = !soft_rst_i && ((state_d != ST_AWAKE) != (state_q != ST_AWAKE));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign asleep_o    = (state_q != ST_AWAKE);
  assign sleep_int_o = pulse_q;

  // R7
  forced_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_sleep_i && !soft_rst_i) |=> asleep_o);

  // R9
  forced_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FORCE_SLP && force_sleep_i && !soft_rst_i) |=> (state_q == ST_FORCE_SLP));

  // R8
  auto_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AUTO_SLP && !force_sleep_i && !soft_rst_i && (activity_i || !auto_sleep_i))
      |=> !asleep_o);

  // R10
  pulse_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_int_o |-> (asleep_o != $past(asleep_o)));

endmodule

// File: rtl/pwr_irq_ctrl.sv
module pwr_irq_ctrl #(
  parameter int unsigned POR_CYCLES  = 64,
  parameter int unsigned IDLE_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst_i,
  input  logic irq_mode_i,
  input  logic auto_sleep_i,
  input  logic force_sleep_i,
  input  logic activity_i,
  input  logic int_pending_i,
  output logic irq_n_o,
  output logic sleep_state_o,
  output logic sleep_int_o,
  output logic clk_en_o
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  logic       ready;
  logic       timeout;
  logic       asleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  pic_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .soft_rst_i (soft_rst_i),
    .ready_o    (ready)
  );

  pic_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .soft_rst_i   (soft_rst_i),
    .auto_sleep_i (auto_sleep_i),
    .awake_i      (!asleep),
    .activity_i   (activity_i),
    .timeout_o    (timeout)
  );

  pic_sleep_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_s_n),
    .soft_rst_i    (soft_rst_i),
    .auto_sleep_i  (auto_sleep_i),
    .force_sleep_i (force_sleep_i),
    .activity_i    (activity_i),
    .timeout_i     (timeout),
    .asleep_o      (asleep),
    .sleep_int_o   (sleep_int_o)
  );

  always_comb begin
    if (!ready)          irq_n_o = 1'b0;
    else if (irq_mode_i) irq_n_o = !int_pending_i;
    else                 irq_n_o = 1'b1;
  end

  assign sleep_state_o = asleep;
  assign clk_en_o      = !asleep;

  // R2
  por_irq_low_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ready |-> !irq_n_o);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_s_n |-> (!irq_n_o && clk_en_o && !sleep_int_o));

endmodule

// File: tb/test_pwr_irq_ctrl.sv
module test_pwr_irq_ctrl;
  localparam int POR  = 64;
  localparam int IDLE = 1024;

  logic clk = 1'b0;
  logic rst_n, soft_rst, irq_mode, auto_slp, force_slp, activity, pending;
  logic irq_n, slp_state, slp_int, clk_en;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;

  always #2 clk = ~clk;

  pwr_irq_ctrl #(.POR_CYCLES(POR), .IDLE_CYCLES(IDLE)) i_pwr_irq_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .soft_rst_i    (soft_rst),
    .irq_mode_i    (irq_mode),
    .auto_sleep_i  (auto_slp),
    .force_sleep_i (force_slp),
    .activity_i    (activity),
    .int_pending_i (pending),
    .irq_n_o       (irq_n),
    .sleep_state_o (slp_state),
    .sleep_int_o   (slp_int),
    .clk_en_o      (clk_en)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic chk_awake(input string req, input logic exp_asleep, input logic exp_pulse);
    chk(req, "sleep_state", slp_state, exp_asleep);
    chk("R11", "clk_en", clk_en, !exp_asleep);
    chk(req, "sleep_int", slp_int, exp_pulse);
  endtask

  task automatic t_reset_powerup;
    rst_n = 0; soft_rst = 0; irq_mode = 0; auto_slp = 0;
    force_slp = 0; activity = 0; pending = 1;
    tick(3);
    chk("R1", "irq_n in reset", irq_n, 1'b0);
    chk_awake("R1", 1'b0, 1'b0);
    rst_n = 1;
    tick(POR + 1);
    chk("R2", "irq_n before ready", irq_n, 1'b0);
    tick(1);
    chk("R2", "irq_n at ready with pending", irq_n, 1'b1);
  endtask

  task automatic t_irq_mode;
    irq_mode = 1; pending = 1; #1;
    chk("R3", "irq_n pending", irq_n, 1'b0);
    pending = 0; #1;
    chk("R3", "irq_n idle", irq_n, 1'b1);
  endtask

  task automatic t_no_auto;
    tick(IDLE + 50);
    chk_awake("R6", 1'b0, 1'b0);
  endtask

  task automatic t_auto_sleep;
    auto_slp = 1;
    tick(IDLE);
    chk_awake("R4", 1'b0, 1'b0);
    tick(1);
    chk_awake("R4", 1'b1, 1'b1);
    tick(1);
    chk_awake("R10", 1'b1, 1'b0);
    activity = 1;
    tick(1);
    activity = 0;
    chk_awake("R8", 1'b0, 1'b1);
    tick(1);
    chk_awake("R10", 1'b0, 1'b0);
  endtask

  task automatic t_activity_restart;
    tick(IDLE - 30);
    activity = 1;
    tick(1);
    activity = 0;
    tick(IDLE);
    chk_awake("R5", 1'b0, 1'b0);
    tick(1);
    chk_awake("R5", 1'b1, 1'b1);
    auto_slp = 0;
    tick(1);
    chk_awake("R8", 1'b0, 1'b1);
  endtask

  task automatic t_forced;
    force_slp = 1; activity = 1;
    tick(1);
    chk_awake("R7", 1'b1, 1'b1);
    tick(3);
    chk_awake("R9", 1'b1, 1'b0);
    activity = 0; auto_slp = 1;
    tick(1);
    force_slp = 0;
    tick(1);
    chk_awake("R9", 1'b0, 1'b1);
    auto_slp = 0;
    tick(1);
    chk_awake("R10", 1'b0, 1'b0);
  endtask

  task automatic t_soft_reset;
    force_slp = 1;
    tick(1);
    chk_awake("R7", 1'b1, 1'b1);
    soft_rst = 1; force_slp = 0; irq_mode = 0;
    tick(1);
    soft_rst = 0;
    chk_awake("R12", 1'b0, 1'b0);
    chk("R12", "irq_n after soft reset", irq_n, 1'b0);
    tick(POR - 1);
    chk("R12", "irq_n before ready", irq_n, 1'b0);
    tick(1);
    chk("R12", "irq_n ready again", irq_n, 1'b1);
  endtask

  initial begin
    t_reset_powerup();
    t_irq_mode();
    t_no_auto();
    t_auto_sleep();
    t_activity_restart();
    t_forced();
    t_soft_reset();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule